// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a register-programmed master for the two-wire MDIO management bus. It sends Clause 22 and Clause 45 frames to external PHY devices. Software sets a clock divider and a clause select in a configuration word. It sets the PHY and device addresses in a control word. It then starts a frame with a single register write. A write to the data word sends a write frame. A write to the address word sends a Clause 45 address frame. A control write with the read bit set sends a read frame. After a read, the captured value can be read back from the data word.

The management clock is made from the system clock by a half-period counter. The bidirectional data line is driven through separate output, output-enable and input signals. A busy flag covers each frame from its launch until the final falling clock edge. While that flag is set, every register write is dropped. The flag also appears on an output pin so that board-level logic can track frame boundaries.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, all four registers read as zero, and mdc, mdio_o and mdio_oe are low.
- R2: The registers sit at word indices 12 (config), 13 (control), 14 (data) and 15 (address) of bus_addr. The config word has busy at bit 0, read-error at bit 1, clause select at bit 6 (1 = Clause 45) and the divider D at bits 15:8. Its other bits read as zero. The control word has the device/register address at bits 4:0, the PHY address at bits 9:5, preamble suppress at bit 10 and read request at bit 15. Its other bits read as zero.
- R3: A write to the data word sends a write frame, MSB first: 32 preamble ones, then the start code (00 for Clause 45, 01 for Clause 22), then op 01, the 5-bit PHY address, the 5-bit device address, the turnaround 1 then 0, and the low 16 bits of the written value.
- R4: In Clause 45 mode, a write to the address word sends the same frame layout with op 00 and the written 16 bits as payload. In Clause 22 mode, the value is only stored and busy stays low.
- R5: A control write with bit 15 set sends a read frame with op 10 (Clause 22) or op 11 (Clause 45). The master releases the line (mdio_oe low) for the 2 turnaround and 16 data slots. After the frame, the data word bits 15:0 return the 16 sampled bits.
- R6: The read-error flag takes the line value sampled in the second turnaround slot of a read. So it is set when no device pulls that slot low. It is cleared when any frame is launched.
- R7: With control bit 10 set, the preamble is left out and the frame is 32 bits long.
- R8: mdc is low when idle. Each mdc phase lasts 2*max(D,1) system clocks. mdio_o and mdio_oe change only as mdc falls, and mdio_i is sampled as mdc rises.
- R9: Busy (config bit 0, data bit 31 and the busy output) rises with the launching write and falls with the last falling mdc edge of the frame.
- R10: Any register write that arrives while busy has no effect: no stored field changes and no frame is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register word index |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |
| xfer_busy | output | 1 | Frame in progress |

## Verification
A PHY model on the bench captures every bit on the line at the rising clock edges. A scoreboard compares each finished frame with one built from the requirements. A wrong start code, opcode, field order or turnaround pattern therefore shows up as a bit mismatch, and a frame that should not exist shows up as an unexpected entry. The bench measures the mdc period for divider values 0, 1 and 3, which catches an off-by-one in the divider or missing handling of zero. It runs reads with and without a responding PHY. A design that sampled the wrong turnaround slot, or that did not clear the error flag, would report the wrong flag. It also writes control, config and data during a frame; a design that did not drop these writes would change the stored fields or start an extra frame. Finally, it writes the address word in Clause 22 mode, where a frame that should not exist would be sent.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int PRE_BITS  = 32;
  localparam int HDR_BITS  = 14;
  localparam int TURN_BITS = 2;
  localparam int DATA_BITS = 16;
  localparam int FRM_BITS  = HDR_BITS + TURN_BITS + DATA_BITS;
  localparam int TOT_BITS  = PRE_BITS + FRM_BITS;
  localparam int IDX_W     = $clog2(TOT_BITS);

  typedef enum logic [1:0] {K_ADDR, K_WRITE, K_READ} fr_kind_e;

  function automatic logic [1:0] op_code(fr_kind_e kind, logic c45);
    case (kind)
      K_ADDR:  return 2'b00;
      K_WRITE: return 2'b01;
      default: return c45 ? 2'b11 : 2'b10;
    endcase
  endfunction

  // Post-preamble frame word, transmitted MSB first.
  function automatic logic [FRM_BITS-1:0] build_frame(logic c45, fr_kind_e kind,
      logic [4:0] port, logic [4:0] dev, logic [DATA_BITS-1:0] payload);
    logic [1:0] st;
    logic [1:0] ta;
    st = c45 ? 2'b00 : 2'b01;
    ta = (kind == K_READ) ? 2'b11 : 2'b10;
    return {st, op_code(kind, c45), port, dev, ta,
            (kind == K_READ) ? {DATA_BITS{1'b1}} : payload};
  endfunction

  // Line value for slot idx: preamble ones, then the frame word.
  function automatic logic slot_bit(logic [FRM_BITS-1:0] frm, logic [IDX_W-1:0] idx);
    logic [IDX_W-1:0] rel;
    rel = idx - IDX_W'(PRE_BITS);
    if (idx < IDX_W'(PRE_BITS)) return 1'b1;
    return frm[IDX_W'(FRM_BITS - 1) - rel];
  endfunction
endpackage

// File: rtl/mdio_mdc_timer.sv
module mdio_mdc_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 2;

  // Phase length in system clocks: twice the field, zero treated as one.
  function automatic logic [CNT_W-1:0] half_len(logic [DIV_W-1:0] d);
    return (d == '0) ? CNT_W'(2) : CNT_W'({d, 1'b0});
  endfunction

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == half_len(div) - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + CNT_W'(1);
  end

  // R8
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  fr_kind_e             kind,
  input  logic                 c45,
  input  logic                 no_pre,
  input  logic [4:0]           port,
  input  logic [4:0]           dev,
  input  logic [DATA_BITS-1:0] payload,
  input  logic                 tick,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 mdc,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 rd_done,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rd_err
);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(PRE_BITS + HDR_BITS);
  localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(PRE_BITS + HDR_BITS + 1);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(PRE_BITS + HDR_BITS + TURN_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOT_BITS - 1);

  logic [IDX_W-1:0]    idx;
  logic [FRM_BITS-1:0] frm;
  fr_kind_e            kind_q;

  wire rise_ev  = busy && tick && !mdc;
  wire fall_ev  = busy && tick && mdc;
  wire last_bit = (idx == LAST_IDX);
  wire released = (kind_q == K_READ) && (idx >= REL_IDX);

  assign mdio_o  = busy && slot_bit(frm, idx);
  assign mdio_oe = busy && !released;
  assign rd_done = fall_ev && last_bit && (kind_q == K_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      mdc     <= 1'b0;
      idx     <= '0;
      frm     <= '0;
      kind_q  <= K_WRITE;
      rx_data <= '0;
      rd_err  <= 1'b0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      mdc    <= 1'b0;
      idx    <= no_pre ? IDX_W'(PRE_BITS) : '0;
      frm    <= build_frame(c45, kind, port, dev, payload);
      kind_q <= kind;
      rd_err <= 1'b0;
    end else if (rise_ev) begin
      mdc <= 1'b1;
      if (kind_q == K_READ) begin
        if (idx == TA2_IDX)  rd_err  <= mdio_i;
        if (idx >= DAT_IDX)  rx_data <= {rx_data[DATA_BITS-2:0], mdio_i};
      end
    end else if (fall_ev) begin
      mdc <= 1'b0;
      if (last_bit) busy <= 1'b0;
      else          idx  <= idx + IDX_W'(1);
    end
  end

  // R8
  line_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !($stable(mdio_o) && $stable(mdio_oe))) |-> ($past(mdc) && !mdc));
  // R8
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  // R9
  end_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mdc));
  // R6
  err_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_err) |-> ($past(busy) && kind_q == K_READ && mdc));
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int BASE_WORD = 12,
  parameter int DIV_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic                 busy,
  input  logic                 rd_err,
  input  logic                 rd_done,
  input  logic [DATA_BITS-1:0] rx_data,
  output logic                 start,
  output fr_kind_e             kind,
  output logic                 c45,
  output logic                 no_pre,
  output logic [4:0]           port,
  output logic [4:0]           dev,
  output logic [DATA_BITS-1:0] payload,
  output logic [DIV_W-1:0]     div
);
  localparam logic [ADDR_W-1:0] CFG_W  = ADDR_W'(BASE_WORD);
  localparam logic [ADDR_W-1:0] CTL_W  = ADDR_W'(BASE_WORD + 1);
  localparam logic [ADDR_W-1:0] DAT_W  = ADDR_W'(BASE_WORD + 2);
  localparam logic [ADDR_W-1:0] ADR_W  = ADDR_W'(BASE_WORD + 3);
  localparam logic [15:0]       CTL_MASK = 16'h87FF;

  logic [15:0]          ctl_q;
  logic [DATA_BITS-1:0] data_q, addr_q;

  wire wr_ok   = bus_wr && !busy;
  wire sel_cfg = (bus_addr == CFG_W);
  wire sel_ctl = (bus_addr == CTL_W);
  wire sel_dat = (bus_addr == DAT_W);
  wire sel_adr = (bus_addr == ADR_W);

  assign start   = wr_ok && (sel_dat || (sel_adr && c45) || (sel_ctl && bus_wdata[15]));
  assign kind    = sel_dat ? K_WRITE : (sel_adr ? K_ADDR : K_READ);
  assign port    = sel_ctl ? bus_wdata[9:5] : ctl_q[9:5];
  assign dev     = sel_ctl ? bus_wdata[4:0] : ctl_q[4:0];
  assign no_pre  = sel_ctl ? bus_wdata[10]  : ctl_q[10];
  assign payload = bus_wdata[DATA_BITS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c45    <= 1'b0;
      div    <= '0;
      ctl_q  <= '0;
      data_q <= '0;
      addr_q <= '0;
    end else begin
      if (wr_ok && sel_cfg) begin
        c45 <= bus_wdata[6];
        div <= bus_wdata[8 +: DIV_W];
      end
      if (wr_ok && sel_ctl) ctl_q  <= bus_wdata[15:0] & CTL_MASK;
      if (wr_ok && sel_adr) addr_q <= bus_wdata[DATA_BITS-1:0];
      if (wr_ok && sel_dat) data_q <= bus_wdata[DATA_BITS-1:0];
      else if (rd_done)     data_q <= rx_data;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_cfg) begin
      bus_rdata[0]          = busy;
      bus_rdata[1]          = rd_err;
      bus_rdata[6]          = c45;
      bus_rdata[8 +: DIV_W] = div;
    end else if (sel_ctl) begin
      bus_rdata[15:0] = ctl_q;
    end else if (sel_dat) begin
      bus_rdata[31]            = busy;
      bus_rdata[DATA_BITS-1:0] = data_q;
    end else if (sel_adr) begin
      bus_rdata[DATA_BITS-1:0] = addr_q;
    end
  end

  // R10
  busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && busy) |=> ($stable(ctl_q) && $stable(addr_q) && $stable(c45) && $stable(div)));
  // R10
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctl_q));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int BASE_WORD = 12,
  parameter int DIV_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i,
  output logic              xfer_busy
);
  logic                 start, c45, no_pre, tick, rd_done, rd_err;
  fr_kind_e             kind;
  logic [4:0]           port, dev;
  logic [DATA_BITS-1:0] payload, rx_data;
  logic [DIV_W-1:0]     div;

  mdio_reg_bank #(.ADDR_W(ADDR_W), .BASE_WORD(BASE_WORD), .DIV_W(DIV_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(xfer_busy),
    .rd_err(rd_err), .rd_done(rd_done), .rx_data(rx_data), .start(start),
    .kind(kind), .c45(c45), .no_pre(no_pre), .port(port), .dev(dev),
    .payload(payload), .div(div));

  mdio_mdc_timer #(.DIV_W(DIV_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(xfer_busy), .div(div), .tick(tick));

  mdio_frame_engine engine_i (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .c45(c45),
    .no_pre(no_pre), .port(port), .dev(dev), .payload(payload), .tick(tick),
    .mdio_i(mdio_i), .busy(xfer_busy), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rd_done(rd_done), .rx_data(rx_data), .rd_err(rd_err));

  // R9
  busy_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_busy) |-> $past(bus_wr));
endmodule

// File: tb/mdio_mgmt_ctrl_tb_top.sv
module mdio_mgmt_ctrl_tb_top;
  localparam logic [3:0] A_CFG = 4'd12, A_CTL = 4'd13, A_DAT = 4'd14, A_ADR = 4'd15;

  typedef struct {
    int          n;
    logic [63:0] bits;
    string       tag;
  } frame_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, xfer_busy;
  logic        phy_val = 1'b1;
  logic        rsp_on = 1'b1;
  logic [15:0] rsp_val = '0;
  wire         line = mdio_oe ? mdio_o : phy_val;

  int checks = 0, fails = 0, rel = 0, ncap = 0;
  logic [63:0] cap = '0;
  frame_t      sb_q[$];
  logic [31:0] rd;

  always #5 clk = ~clk;

  mdio_mgmt_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(line), .xfer_busy(xfer_busy));

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    while (xfer_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic measure(int exp_clks, string req);
    realtime t0;
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc);
    check(($realtime - t0) == exp_clks * 10.0, req, "mdc period clocks",
          longint'(($realtime - t0) / 10.0), exp_clks);
  endtask

  // Expected line bits: optional preamble, 14-bit header, 18-bit tail.
  function automatic frame_t mk(bit c45, bit [1:0] op, bit [4:0] pa, bit [4:0] da,
                                bit [17:0] tail, bit pre, string tag);
    frame_t f;
    logic [31:0] body;
    body = {c45 ? 2'b00 : 2'b01, op, pa, da, tail};
    f.n    = pre ? 64 : 32;
    f.bits = pre ? {32'hFFFF_FFFF, body} : {32'h0, body};
    f.tag  = tag;
    return f;
  endfunction

  // PHY responder: presents released-slot values after each falling mdc.
  always @(negedge mdc) begin
    #1;
    if (mdio_oe) begin
      rel = 0; phy_val = 1'b1;
    end else begin
      if (!rsp_on || rel == 0 || rel > 17) phy_val = 1'b1;
      else if (rel == 1)                   phy_val = 1'b0;
      else                                 phy_val = rsp_val[17 - rel];
      rel++;
    end
  end

  always @(posedge mdc) begin
    cap = {cap[62:0], line};
    ncap++;
  end

  // Scoreboard monitor: one expected frame per busy interval.
  initial forever begin
    frame_t e;
    @(posedge xfer_busy);
    ncap = 0; cap = '0;
    @(negedge xfer_busy);
    if (sb_q.size() == 0) begin
      check(1'b0, "R10", "unexpected frame", ncap, 0);
    end else begin
      e = sb_q.pop_front();
      check(ncap == e.n, e.tag, "frame length", ncap, e.n);
      check(cap == e.bits, e.tag, "frame bits", cap, e.bits);
    end
  end

  initial begin
    #2_000_000;
    check(1'b0, "R9", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(A_CFG, rd); check(rd == 0, "R1", "cfg after reset", rd, 0);
    bus_read(A_CTL, rd); check(rd == 0, "R1", "ctl after reset", rd, 0);
    bus_read(A_DAT, rd); check(rd == 0, "R1", "data after reset", rd, 0);
    check({mdc, mdio_o, mdio_oe} == 3'b000, "R1", "pins after reset", {mdc, mdio_o, mdio_oe}, 0);

    // R2 field readback
    bus_write(A_CFG, 32'hFFFF_01BC);
    bus_read(A_CFG, rd); check(rd == 32'h0000_0100, "R2", "cfg readback", rd, 32'h100);
    bus_write(A_CTL, 32'h0000_722A);
    bus_read(A_CTL, rd); check(rd == 32'h0000_022A, "R2", "ctl readback", rd, 32'h22A);

    // R3 Clause 22 write, R8 period with D=1, R9 busy bits
    sb_q.push_back(mk(0, 2'b01, 5'h11, 5'h0A, {2'b10, 16'hBEEF}, 1, "R3"));
    bus_write(A_DAT, 32'h0000_BEEF);
    check(xfer_busy == 1'b1, "R9", "busy pin after launch", xfer_busy, 1);
    bus_read(A_CFG, rd); check(rd[0] == 1'b1, "R9", "cfg busy bit", rd[0], 1);
    bus_read(A_DAT, rd); check(rd[31] == 1'b1, "R9", "data bit31", rd[31], 1);
    measure(4, "R8");
    wait_idle();
    bus_read(A_CFG, rd); check(rd[0] == 1'b0, "R9", "busy after frame", rd[0], 0);
    bus_read(A_DAT, rd); check(rd == 32'h0000_BEEF, "R3", "data after write", rd, 32'hBEEF);

    // R10 writes during a frame are dropped
    sb_q.push_back(mk(0, 2'b01, 5'h11, 5'h0A, {2'b10, 16'h1234}, 1, "R10"));
    bus_write(A_DAT, 32'h0000_1234);
    bus_write(A_CTL, 32'h0000_83FF);
    bus_write(A_DAT, 32'h0000_5555);
    bus_write(A_CFG, 32'h0000_0540);
    bus_write(A_ADR, 32'h0000_9999);
    wait_idle();
    bus_read(A_CTL, rd); check(rd == 32'h0000_022A, "R10", "ctl kept", rd, 32'h22A);
    bus_read(A_CFG, rd); check(rd == 32'h0000_0100, "R10", "cfg kept", rd, 32'h100);
    bus_read(A_DAT, rd); check(rd == 32'h0000_1234, "R10", "data kept", rd, 32'h1234);
    bus_read(A_ADR, rd); check(rd == 32'h0, "R10", "addr kept", rd, 0);

    // R5 Clause 22 read with responder
    rsp_on = 1'b1; rsp_val = 16'hA5C3;
    sb_q.push_back(mk(0, 2'b10, 5'h11, 5'h0A, {2'b10, 16'hA5C3}, 1, "R5"));
    bus_write(A_CTL, 32'h0000_822A);
    wait_idle();
    bus_read(A_DAT, rd); check(rd == 32'h0000_A5C3, "R5", "c22 read data", rd, 32'hA5C3);
    bus_read(A_CFG, rd); check(rd[1] == 1'b0, "R6", "no error with responder", rd[1], 0);

    // R4 address write in Clause 22 mode only stores
    bus_write(A_ADR, 32'h0000_0077);
    check(xfer_busy == 1'b0, "R4", "no frame in c22", xfer_busy, 0);
    bus_read(A_ADR, rd); check(rd == 32'h77, "R4", "addr stored", rd, 32'h77);

    // R4 Clause 45 address frame, R8 period with D=3
    bus_write(A_CFG, 32'h0000_0340);
    bus_read(A_CFG, rd); check(rd == 32'h0000_0340, "R2", "cfg c45 readback", rd, 32'h340);
    sb_q.push_back(mk(1, 2'b00, 5'h11, 5'h0A, {2'b10, 16'h1357}, 1, "R4"));
    bus_write(A_ADR, 32'h0000_1357);
    measure(12, "R8");
    wait_idle();

    // R3 Clause 45 write
    sb_q.push_back(mk(1, 2'b01, 5'h11, 5'h0A, {2'b10, 16'h0F0F}, 1, "R3"));
    bus_write(A_DAT, 32'h0000_0F0F);
    wait_idle();

    // R7 + R5 Clause 45 read without preamble
    rsp_val = 16'h3C3C;
    sb_q.push_back(mk(1, 2'b11, 5'h03, 5'h1E, {2'b10, 16'h3C3C}, 0, "R7"));
    bus_write(A_CTL, 32'h0000_847E);
    wait_idle();
    bus_read(A_DAT, rd); check(rd == 32'h0000_3C3C, "R5", "c45 read data", rd, 32'h3C3C);

    // R6 read with no responder
    rsp_on = 1'b0;
    sb_q.push_back(mk(1, 2'b11, 5'h03, 5'h1E, 18'h3FFFF, 1, "R6"));
    bus_write(A_CTL, 32'h0000_807E);
    wait_idle();
    bus_read(A_CFG, rd); check(rd[1] == 1'b1, "R6", "error flag set", rd[1], 1);
    bus_read(A_DAT, rd); check(rd == 32'h0000_FFFF, "R6", "undriven data", rd, 32'hFFFF);

    // R6 cleared on next launch; R8 D=0 acts as 1
    bus_write(A_CFG, 32'h0000_0040);
    sb_q.push_back(mk(1, 2'b01, 5'h03, 5'h1E, {2'b10, 16'h8001}, 1, "R8"));
    bus_write(A_DAT, 32'h0000_8001);
    bus_read(A_CFG, rd); check(rd[1] == 1'b0, "R6", "error cleared on launch", rd[1], 0);
    measure(4, "R8");
    wait_idle();

    check(sb_q.size() == 0, "R3", "frames left in scoreboard", sb_q.size(), 0);
    finish_up();
  end
endmodule